// File: doc/BRIEF.md
# Completion Entry Ordering Gate

The gate sits between a producer of completion entries and the logic that writes them into a completion ring. Entries arrive on a valid/ready slave port. Each entry carries a 512-bit data word, a size code, sixteen lane parity bits, a queue ID, a port ID, a completion-type code, a 16-bit payload packet ID to wait on, a marker flag and a marker no-write-back flag. The gate checks the parity of every 32-bit lane and rejects reserved type codes. It clears the lanes beyond the encoded size. It then holds the entry until a side strobe reports that the payload packet it names has been sent, and forwards it on a valid/ready master port. A marker entry with its no-write-back flag set goes through the same queue and wait path, but it never reaches the ring. Once it would have left, the gate reports it on a marker-done pulse.

The gate holds at most one entry. The input port is not ready from the cycle after an entry is accepted until the cycle after that entry leaves, so entries always stay in their arrival order. Input back-pressure rules: once in_valid is raised it must stay high, with its fields stable, until a cycle where in_ready is high. Output back-pressure rules: once out_valid is raised, the gate keeps it high and keeps every output field stable until out_ready is seen high. A faulty entry never holds the port: its error pulse comes out one cycle after acceptance, and in_ready stays high.

The payload tracker keeps the furthest packet ID reported so far, using 16-bit wraparound order. A waiting entry is released when that recorded ID equals its wait ID or is ahead of it. Before the first strobe, no waiting entry is released.

Top module: `cmpt_order_gate`

## Requirements
- R1: The size code selects how many 32-bit lanes are kept: 00 keeps lanes 0-1 (8 bytes), 01 keeps lanes 0-3, 10 keeps lanes 0-7 and 11 keeps all 16. Lanes above that are zero on out_data, and out_size repeats the code.
- R2: Lane k (data bits 32k+31..32k) fails when the XOR of its 32 data bits and in_par[k] is 0, which means odd parity is required. An entry with any failing lane is dropped, and err_valid pulses for one cycle, in the cycle after acceptance, with err_lanes set to the mask of failing lanes.
- R3: Type code 10 is reserved. Such an entry is dropped, and err_valid pulses in the cycle after acceptance with err_rsvd=1. err_rsvd is 0 on a pure parity error.
- R4: An entry of type 00 is forwarded with no wait: out_valid is high in the cycle after acceptance.
- R5: An entry of type 01 or 11 is held until the recorded sent ID minus in_wait_id, taken as a signed 16-bit value, is 0 or more. out_valid rises in the cycle after the satisfying sent_valid strobe. If the condition already holds, it rises in the cycle after acceptance. Before any strobe, no entry of type 01 or 11 is released.
- R6: A sent_valid strobe whose ID is behind the recorded one (a signed 16-bit difference of 0 or less) does not change the recorded ID. A strobe whose ID is ahead replaces it, even across the 16-bit wrap.
- R7: in_ready is high after reset. It is low from the cycle after an entry is accepted into the hold stage until the cycle after that entry is forwarded or dropped. Outputs appear in acceptance order.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_size, out_qid, out_port and out_marker hold their values.
- R9: A marker entry with in_nowb=1 never raises out_valid. In the cycle after it is released, mark_done pulses for one cycle and mark_qid carries its queue ID. A marker entry with in_nowb=0 is forwarded with out_marker=1.
- R10: out_qid and out_port carry the queue ID and port ID of the entry being forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Gate can accept an entry |
| in_data | input | 512 | Entry data word |
| in_size | input | 2 | Size code (00 8B, 01 16B, 10 32B, 11 64B) |
| in_par | input | 16 | Odd parity bit per 32-bit lane |
| in_qid | input | 11 | Queue ID |
| in_port | input | 3 | Port ID |
| in_marker | input | 1 | Entry is a flush marker |
| in_nowb | input | 1 | Marker is not to be written to the ring |
| in_ctype | input | 2 | Type: 00 no wait, 01 wait without payload, 10 reserved, 11 wait for own payload |
| in_wait_id | input | 16 | Payload packet ID to wait for |
| sent_valid | input | 1 | Payload packet sent strobe |
| sent_id | input | 16 | ID of the sent payload packet |
| out_valid | output | 1 | Entry offered to the ring writer |
| out_ready | input | 1 | Ring writer accepts |
| out_data | output | 512 | Trimmed entry data |
| out_size | output | 2 | Size code of the entry |
| out_qid | output | 11 | Queue ID of the entry |
| out_port | output | 3 | Port ID of the entry |
| out_marker | output | 1 | Forwarded entry is a marker |
| err_valid | output | 1 | One-cycle pulse: entry dropped as faulty |
| err_lanes | output | 16 | Failing lane mask for the dropped entry |
| err_rsvd | output | 1 | Dropped entry had the reserved type |
| mark_done | output | 1 | One-cycle pulse: suppressed marker retired |
| mark_qid | output | 11 | Queue ID of the retired marker |

## Verification
A stuck or wrongly compared payload tracker shows first as an entry that is released early or held too long. In the former case out_valid rises before the satisfying strobe; in the latter, in_ready stays low, and both show within a cycle of the strobe. A hold stage that loads the wrong fields, or does not clear, shows at the next output transfer as a mismatch against the expected entry, or as in_ready stuck low. A parity or type decode error shows one cycle after acceptance, as a missing, spurious or wrongly masked err_valid pulse, or as an entry that leaks onto the output port.

// File: rtl/cmpt_gate_pkg.sv
package cmpt_gate_pkg;
  typedef enum logic [1:0] {
    CT_NOWAIT   = 2'b00,
    CT_WAITONLY = 2'b01,
    CT_RSVD     = 2'b10,
    CT_PAYLOAD  = 2'b11
  } ctype_e;
endpackage

// File: rtl/cmpt_lane_parity.sv
module cmpt_lane_parity #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  localparam int DW = LANES * LANE_W
) (
  input  logic [DW-1:0]    data,
  input  logic [LANES-1:0] par,
  output logic [LANES-1:0] bad
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // odd parity: the lane bits together with their parity bit XOR to one
    assign bad[k] = ~(^{data[k*LANE_W +: LANE_W], par[k]});
  end
endmodule

// File: rtl/cmpt_size_trim.sv
module cmpt_size_trim #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  localparam int DW = LANES * LANE_W
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    size,
  output logic [DW-1:0] trimmed
);
  // size 3 keeps every lane, each smaller code halves the count
  logic [$clog2(LANES):0] keep;
  always_comb keep = ($clog2(LANES)+1)'(LANES >> (2'd3 - size));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign trimmed[k*LANE_W +: LANE_W] =
      (k < int'(keep)) ? data[k*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/cmpt_sent_tracker.sv
module cmpt_sent_tracker #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sent_valid,
  input  logic [ID_W-1:0] sent_id,
  input  logic [ID_W-1:0] wait_id,
  output logic            satisfied
);
  logic            seen;
  logic [ID_W-1:0] top_id;
  logic [ID_W-1:0] ahead;
  logic [ID_W-1:0] margin;

  always_comb begin
    ahead  = sent_id - top_id;
    margin = top_id - wait_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      top_id <= '0;
    end else if (sent_valid && (!seen || (!ahead[ID_W-1] && ahead != '0))) begin
      seen   <= 1'b1;
      top_id <= sent_id;
    end
  end

  assign satisfied = seen && !margin[ID_W-1];
endmodule

// File: rtl/cmpt_order_gate.sv
module cmpt_order_gate
  import cmpt_gate_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  parameter int QID_W  = 11,
  parameter int PORT_W = 3,
  parameter int PID_W  = 16,
  localparam int DW = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [1:0]        in_size,
  input  logic [LANES-1:0]  in_par,
  input  logic [QID_W-1:0]  in_qid,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_marker,
  input  logic              in_nowb,
  input  logic [1:0]        in_ctype,
  input  logic [PID_W-1:0]  in_wait_id,
  input  logic              sent_valid,
  input  logic [PID_W-1:0]  sent_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [1:0]        out_size,
  output logic [QID_W-1:0]  out_qid,
  output logic [PORT_W-1:0] out_port,
  output logic              out_marker,
  output logic              err_valid,
  output logic [LANES-1:0]  err_lanes,
  output logic              err_rsvd,
  output logic              mark_done,
  output logic [QID_W-1:0]  mark_qid
);
  typedef struct packed {
    logic [DW-1:0]     data;
    logic [1:0]        size;
    logic [QID_W-1:0]  qid;
    logic [PORT_W-1:0] port;
    logic              marker;
    logic              drop;
    logic              nowait;
    logic [PID_W-1:0]  wait_id;
  } held_t;

  logic [LANES-1:0] bad_lanes;
  logic [DW-1:0]    trimmed;
  logic             satisfied;
  logic             hold_valid;
  logic             hold_rel;
  held_t            hold;
  logic             accept, faulty, type_rsvd;
  logic             released, fwd_now, drop_now;

  cmpt_lane_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par (
    .data(in_data), .par(in_par), .bad(bad_lanes)
  );

  cmpt_size_trim #(.LANES(LANES), .LANE_W(LANE_W)) u_trim (
    .data(in_data), .size(in_size), .trimmed(trimmed)
  );

  cmpt_sent_tracker #(.ID_W(PID_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .sent_valid(sent_valid), .sent_id(sent_id),
    .wait_id(hold.wait_id), .satisfied(satisfied)
  );

  always_comb begin
    in_ready  = !hold_valid;
    accept    = in_valid && in_ready;
    type_rsvd = (ctype_e'(in_ctype) == CT_RSVD);
    faulty    = type_rsvd || (bad_lanes != '0);
    // once released an entry stays released, so the output cannot fall back
    released  = hold_valid && (hold_rel || hold.nowait || satisfied);
    out_valid = released && !hold.drop;
    fwd_now   = out_valid && out_ready;
    drop_now  = released && hold.drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_rel   <= 1'b0;
      hold       <= '0;
      err_valid  <= 1'b0;
      err_lanes  <= '0;
      err_rsvd   <= 1'b0;
      mark_done  <= 1'b0;
      mark_qid   <= '0;
    end else begin
      err_valid <= accept && faulty;
      if (accept && faulty) begin
        err_lanes <= bad_lanes;
        err_rsvd  <= type_rsvd;
      end
      mark_done <= drop_now;
      if (drop_now) mark_qid <= hold.qid;

      if (accept && !faulty) begin
        hold_valid     <= 1'b1;
        hold_rel       <= 1'b0;
        hold.data      <= trimmed;
        hold.size      <= in_size;
        hold.qid       <= in_qid;
        hold.port      <= in_port;
        hold.marker    <= in_marker;
        hold.drop      <= in_marker && in_nowb;
        hold.nowait    <= (ctype_e'(in_ctype) == CT_NOWAIT);
        hold.wait_id   <= in_wait_id;
      end else if (fwd_now || drop_now) begin
        hold_valid <= 1'b0;
        hold_rel   <= 1'b0;
      end else if (released) begin
        hold_rel <= 1'b1;
      end
    end
  end

  always_comb begin
    out_data   = hold.data;
    out_size   = hold.size;
    out_qid    = hold.qid;
    out_port   = hold.port;
    out_marker = hold.marker;
  end
endmodule

// File: rtl/cmpt_order_gate_chk.sv
module cmpt_order_gate_chk #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  parameter int QID_W  = 11,
  localparam int DW = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [1:0]       out_size,
  input logic [QID_W-1:0] out_qid,
  input logic             err_valid,
  input logic [LANES-1:0] err_lanes,
  input logic             err_rsvd,
  input logic             mark_done
);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_size) && $stable(out_qid)));

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready || err_valid));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_rsvd || err_lanes != '0));

  assert_marker_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mark_done |-> !out_valid);

  assert_trim_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_size != 2'b11) |-> (out_data[DW-1:DW/2] == '0));
endmodule

bind cmpt_order_gate cmpt_order_gate_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .QID_W(QID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_size(out_size), .out_qid(out_qid), .err_valid(err_valid),
  .err_lanes(err_lanes), .err_rsvd(err_rsvd), .mark_done(mark_done)
);

// File: tb/cmpt_order_gate_tb_top.sv
module cmpt_order_gate_tb_top;
  localparam int LANES = 16;
  localparam int DW    = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            in_valid = 0, in_ready;
  logic [DW-1:0]   in_data = '0;
  logic [1:0]      in_size = '0;
  logic [15:0]     in_par = '0;
  logic [10:0]     in_qid = '0;
  logic [2:0]      in_port = '0;
  logic            in_marker = 0, in_nowb = 0;
  logic [1:0]      in_ctype = '0;
  logic [15:0]     in_wait_id = '0;
  logic            sent_valid = 0;
  logic [15:0]     sent_id = '0;
  logic            out_valid, out_ready = 1'b1;
  logic [DW-1:0]   out_data;
  logic [1:0]      out_size;
  logic [10:0]     out_qid;
  logic [2:0]      out_port;
  logic            out_marker;
  logic            err_valid;
  logic [15:0]     err_lanes;
  logic            err_rsvd;
  logic            mark_done;
  logic [10:0]     mark_qid;

  cmpt_order_gate dut_i (.*);

  typedef struct packed {
    logic [DW-1:0] data;
    logic [1:0]    size;
    logic [10:0]   qid;
    logic [2:0]    port;
    logic          marker;
  } item_t;

  item_t       exp_q[$];
  logic [16:0] err_q[$];
  logic [10:0] mark_q[$];
  int n_chk = 0, n_fail = 0;
  bit bp_mode = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] trim(input logic [DW-1:0] d, input logic [1:0] s);
    int keep = 2 << s;
    logic [DW-1:0] r = '0;
    for (int k = 0; k < keep; k++) r[k*32 +: 32] = d[k*32 +: 32];
    return r;
  endfunction

  task automatic send(input logic [1:0] size, input logic [10:0] qid,
                      input logic [2:0] port, input bit marker, input bit nowb,
                      input logic [1:0] ct, input logic [15:0] wid,
                      input logic [15:0] flip);
    logic [DW-1:0] d;
    logic [15:0] p;
    item_t it;
    for (int k = 0; k < LANES; k++) begin
      d[k*32 +: 32] = $urandom;
      p[k] = ~(^d[k*32 +: 32]);
    end
    p = p ^ flip;
    if (flip != 0 || ct == 2'b10) err_q.push_back({flip, ct == 2'b10});
    else if (marker && nowb) mark_q.push_back(qid);
    else begin
      it.data = trim(d, size); it.size = size; it.qid = qid;
      it.port = port; it.marker = marker;
      exp_q.push_back(it);
    end
    @(negedge clk);
    in_valid = 1; in_data = d; in_par = p; in_size = size; in_qid = qid;
    in_port = port; in_marker = marker; in_nowb = nowb; in_ctype = ct;
    in_wait_id = wid;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic strobe(input logic [15:0] id);
    @(negedge clk);
    sent_valid = 1; sent_id = id;
    @(negedge clk);
    sent_valid = 0;
  endtask

  task automatic expect_held(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(!out_valid, req, DW'(out_valid), '0);
      chk(!in_ready, "R7", DW'(in_ready), '0);
      @(negedge clk);
    end
  endtask

  task automatic drain;
    for (int i = 0; i < 200 && (exp_q.size() + err_q.size() + mark_q.size()) != 0; i++)
      @(negedge clk);
    chk(exp_q.size() == 0 && err_q.size() == 0 && mark_q.size() == 0, "R7 drain",
        DW'(exp_q.size() + err_q.size() + mark_q.size()), '0);
  endtask

  // out_ready is driven just after the rising edge
  always @(posedge clk) begin
    #1 out_ready = bp_mode ? 1'($urandom) : 1'b1;
  end

  // scoreboard monitor
  logic          pv = 0, pr = 0;
  logic [DW-1:0] pd;
  logic [10:0]   pq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(out_valid && out_data == pd && out_qid == pq, "R8", out_data, pd);
      pv = out_valid; pr = out_ready; pd = out_data; pq = out_qid;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected output", DW'(out_qid), '0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          chk(out_data == e.data, "R1 data", out_data, e.data);
          chk(out_size == e.size, "R1 size", DW'(out_size), DW'(e.size));
          chk(out_qid == e.qid && out_port == e.port, "R10",
              DW'({out_qid, out_port}), DW'({e.qid, e.port}));
          chk(out_marker == e.marker, "R9 marker", DW'(out_marker), DW'(e.marker));
        end
      end
      if (err_valid) begin
        if (err_q.size() == 0) chk(0, "R2 unexpected error", DW'(err_lanes), '0);
        else begin
          logic [16:0] ee;
          ee = err_q.pop_front();
          chk(err_lanes == ee[16:1], "R2 lanes", DW'(err_lanes), DW'(ee[16:1]));
          chk(err_rsvd == ee[0], "R3 rsvd", DW'(err_rsvd), DW'(ee[0]));
        end
      end
      if (mark_done) begin
        if (mark_q.size() == 0) chk(0, "R9 unexpected marker", DW'(mark_qid), '0);
        else begin
          logic [10:0] mq;
          mq = mark_q.pop_front();
          chk(mark_qid == mq, "R9 qid", DW'(mark_qid), DW'(mq));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !out_valid && !err_valid && !mark_done, "R7 reset",
        DW'({in_ready, out_valid, err_valid, mark_done}), DW'(4'b1000));

    // R4 and R1: no-wait entries, every size
    for (int s = 0; s < 4; s++) send(2'(s), 11'(100 + s), 3'(s), 0, 0, 2'b00, 0, 0);
    // R4 timing: out_valid in the cycle after acceptance
    send(2'b11, 11'h7ff, 3'd7, 0, 0, 2'b00, 0, 0);
    chk(out_valid, "R4 timing", DW'(out_valid), 1);
    drain();

    // R2 parity faults, R3 reserved type
    send(2'b11, 11'd5, 3'd1, 0, 0, 2'b00, 0, 16'h0208);
    chk(err_valid && in_ready, "R2 pulse", DW'({err_valid, in_ready}), 2'b11);
    @(negedge clk);
    chk(!err_valid, "R2 one cycle", DW'(err_valid), 0);
    send(2'b00, 11'd6, 3'd2, 0, 0, 2'b10, 0, 0);
    send(2'b01, 11'd7, 3'd3, 0, 0, 2'b10, 0, 16'h8001);
    drain();

    // R5: waits before any strobe
    send(2'b10, 11'd20, 3'd4, 0, 0, 2'b11, 16'd5, 0);
    expect_held("R5 no strobe", 4);
    strobe(16'd3);
    expect_held("R5 behind", 3);
    strobe(16'd5);
    drain();

    // R6: older strobe ignored, later wait satisfied at once
    strobe(16'd4);
    send(2'b00, 11'd21, 3'd5, 0, 0, 2'b01, 16'd5, 0);
    chk(out_valid, "R5 already met", DW'(out_valid), 1);
    drain();
    send(2'b01, 11'd22, 3'd6, 0, 0, 2'b01, 16'd6, 0);
    expect_held("R5 wait 6", 2);
    strobe(16'hfff0);
    expect_held("R6 old strobe", 3);
    strobe(16'd6);
    drain();
    // R6 wrap: 6 -> 0x8005 -> 0x0002 all advance
    strobe(16'h8005);
    strobe(16'h0002);
    send(2'b00, 11'd23, 3'd0, 0, 0, 2'b11, 16'h0001, 0);
    chk(out_valid, "R6 wrap", DW'(out_valid), 1);
    drain();

    // R9 markers
    send(2'b00, 11'd300, 3'd1, 1, 1, 2'b00, 0, 0);
    chk(!out_valid, "R9 suppressed", DW'(out_valid), 0);
    @(negedge clk);
    chk(mark_done && mark_qid == 11'd300, "R9 pulse", DW'({mark_done, mark_qid}),
        DW'({1'b1, 11'd300}));
    send(2'b01, 11'd301, 3'd2, 1, 0, 2'b00, 0, 0);
    send(2'b00, 11'd302, 3'd3, 1, 1, 2'b01, 16'd9, 0);
    expect_held("R9 marker waits", 2);
    strobe(16'd9);
    drain();

    // R8 and R7 under random back-pressure
    bp_mode = 1;
    for (int i = 0; i < 24; i++)
      send(2'($urandom), 11'(400 + i), 3'(i), 0, 0, 2'b00, 0, 0);
    drain();
    bp_mode = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule